// File: doc/BRIEF.md
# Li-Ion Charge Control Sequencer

This block is the digital sequencer of a single-cell lithium charger. It receives comparator flags from the analog front end and two active-low control pins. From these it chooses the current mode that the regulation loops apply: off, short-circuit trickle, precharge, or fast charge with voltage regulation. It runs the precharge, fast-charge and taper safety timers. It drives two open-drain status indications and a power-good indication.

Every comparator flag is synchronized and then debounced for a programmable number of cycles before the state machine acts on it. The control pins are synchronized only, so that their falling edges can be detected. All timers advance on a shared prescaled tick, so the nominal timer lengths follow from the tick limits and the prescaler. The battery-absent test itself lives outside the block. The sequencer raises a request, waits for a done strobe, and reads a present/absent result with that strobe.

Top module: `li_charge_seq`

## Requirements
- R1: With a valid supply and charging enabled, a low battery flag selects precharge (mode 2'b10) and runs the precharge timer. Clearing the flag moves to fast charge (mode 2'b11). If the timer reaches PRE_TICKS ticks first, the charger turns off (mode 2'b00) and holds a timer fault.
- R2: Entering fast charge clears all three timers. With timer/termination enabled, fast charge that lasts FAST_TICKS ticks without termination ends in a timer fault.
- R3: In fast charge the taper timer counts ticks while the taper flag is set and returns to zero when the flag drops. When it reaches TAPER_TICKS ticks, charge is done.
- R4: The termination flag ends fast charge as done on the next decision cycle, without waiting for the taper timer.
- R5: While the temperature-in-window flag is low or the die-hot flag is high, the charging states drive mode 2'b00 and all timers hold their values. Charging resumes from the held values when the condition clears.
- R6: A high charge-enable pin disables charging (mode 2'b00, both status indications off). A falling edge on it clears the timers and any fault and starts a new cycle: precharge if the battery is low, otherwise fast charge.
- R7: While the timer/termination-enable pin is high, the fast-charge timer, the taper expiry and the termination flag have no effect. A falling edge on that pin clears all timers.
- R8: The status encoding is as follows. Charge in progress (not suspended) gives stat1 on and stat2 off. Done gives stat1 off and stat2 on. Every other state gives both off.
- R9: In done, a cleared above-recharge flag raises the absent-check request. A done strobe with present=1 restarts charging. With present=0 the block enters an absent state with both status indications off.
- R10: When the supply-valid flag is low, the block sleeps: power-good off, both status indications off, mode 2'b00. A returning supply starts a new cycle.
- R11: A flag acts only after it has held a new value for DEB_CYC cycles past a two-stage synchronizer. Shorter pulses are ignored.
- R12: In precharge with the short-circuit flag set, the mode is short-circuit trickle (2'b01).
- R13: From a timer fault, once the above-recharge flag has been seen high and then goes low, the block clears the fault and raises the absent-check request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bat_low_i | input | 1 | Battery below low-voltage threshold |
| bat_short_i | input | 1 | Battery below short-circuit threshold |
| bat_full_i | input | 1 | Battery above recharge threshold |
| taper_i | input | 1 | Charge current below taper level |
| term_i | input | 1 | Charge current below termination level |
| temp_ok_i | input | 1 | Pack temperature inside window |
| die_hot_i | input | 1 | Die over-temperature |
| supply_ok_i | input | 1 | Input supply valid |
| chg_en_n_i | input | 1 | Charge enable, active low |
| tmr_en_n_i | input | 1 | Timer and termination enable, active low |
| chk_done_i | input | 1 | Absent check finished (one-cycle strobe) |
| chk_present_i | input | 1 | Absent check result, 1 = battery present |
| mode_o | output | 2 | 00 off, 01 short-circuit, 10 precharge, 11 fast |
| stat1_on_o | output | 1 | Status 1 transistor on |
| stat2_on_o | output | 1 | Status 2 transistor on |
| pgood_o | output | 1 | Power good transistor on |
| chk_req_o | output | 1 | Absent check requested |

## Verification
A comparator flag change first reaches the state machine at clock edge 2+DEB_CYC after it is sampled. The state machine acts on the edge after that, and the outputs follow combinationally from the registered state. A pin falling edge acts on the third edge after sampling. A timer expiry acts one edge after the count reaches its limit. The bench keeps a behavioural reference with the same edge accounting and compares every output at each falling clock edge. Because every output depends only on registered state, each comparison sees settled values and is never racing a stimulus change. The absent-check strobe is sampled on the edge that follows it.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP, ST_DIS, ST_PRE, ST_FAST, ST_DONE, ST_ABS, ST_FAULT, ST_NOBAT
  } chg_state_t;

  typedef enum logic [1:0] {
    MD_OFF = 2'b00, MD_SHORT = 2'b01, MD_PRE = 2'b10, MD_FAST = 2'b11
  } chg_mode_t;

  localparam int unsigned F_LOW    = 0;
  localparam int unsigned F_SHORT  = 1;
  localparam int unsigned F_FULL   = 2;
  localparam int unsigned F_TAPER  = 3;
  localparam int unsigned F_TERM   = 4;
  localparam int unsigned F_TEMP   = 5;
  localparam int unsigned F_HOT    = 6;
  localparam int unsigned F_SUPPLY = 7;
  localparam int unsigned NFLAG    = 8;

  function automatic logic f_suspend(logic temp_ok, logic die_hot);
    return !temp_ok || die_hot;
  endfunction

  function automatic chg_mode_t f_mode(chg_state_t st, logic susp, logic shortf);
    if (susp) return MD_OFF;
    if (st == ST_PRE) return shortf ? MD_SHORT : MD_PRE;
    if (st == ST_FAST) return MD_FAST;
    return MD_OFF;
  endfunction
endpackage

// File: rtl/chg_debounce.sv
module chg_debounce #(
  parameter int unsigned DEB_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic flt_o
);
  localparam int unsigned CW = $clog2(DEB_CYC + 1);

  logic          s1_q, s2_q, q_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      q_q   <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (s2_q == q_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(DEB_CYC - 1)) begin
        q_q   <= s2_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign flt_o = q_q;
endmodule

// File: rtl/chg_timer.sv
module chg_timer #(
  parameter int unsigned LIMIT = 2065,
  localparam int unsigned W    = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         zero_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o,
  output logic         exp_o
);
  logic [W-1:0] cnt_q;

  assign exp_o = (cnt_q >= W'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr_i || zero_i)  cnt_q <= '0;
    else if (step_i && !exp_o) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R2: the counter saturates at its limit
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= W'(LIMIT));
endmodule

// File: rtl/li_charge_seq.sv
module li_charge_seq
  import chg_pkg::*;
#(
  parameter int unsigned DEB_CYC     = 16,
  parameter int unsigned PRESCALE    = 1000,
  parameter int unsigned PRE_TICKS   = 2065,
  parameter int unsigned TAPER_TICKS = 2065,
  parameter int unsigned FAST_TICKS  = 20650
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bat_low_i,
  input  logic       bat_short_i,
  input  logic       bat_full_i,
  input  logic       taper_i,
  input  logic       term_i,
  input  logic       temp_ok_i,
  input  logic       die_hot_i,
  input  logic       supply_ok_i,
  input  logic       chg_en_n_i,
  input  logic       tmr_en_n_i,
  input  logic       chk_done_i,
  input  logic       chk_present_i,
  output logic [1:0] mode_o,
  output logic       stat1_on_o,
  output logic       stat2_on_o,
  output logic       pgood_o,
  output logic       chk_req_o
);
  localparam int unsigned PSW = $clog2(PRESCALE + 1);
  localparam int unsigned PW  = $clog2(PRE_TICKS + 1);
  localparam int unsigned TW  = $clog2(TAPER_TICKS + 1);
  localparam int unsigned FW  = $clog2(FAST_TICKS + 1);

  // ---------------- flag conditioning ----------------
  logic [NFLAG-1:0] raw, flt;
  assign raw = {supply_ok_i, die_hot_i, temp_ok_i, term_i,
                taper_i, bat_full_i, bat_short_i, bat_low_i};

  for (genvar g = 0; g < NFLAG; g++) begin : g_deb
    chg_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
      .clk(clk), .rst_n(rst_n), .raw_i(raw[g]), .flt_o(flt[g]));
  end

  // ---------------- pin synchronizers ----------------
  logic ce1_q, ce2_q, cep_q, te1_q, te2_q, tep_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ce1_q, ce2_q, cep_q} <= 3'b111;
      {te1_q, te2_q, tep_q} <= 3'b111;
    end else begin
      ce1_q <= chg_en_n_i; ce2_q <= ce1_q; cep_q <= ce2_q;
      te1_q <= tmr_en_n_i; te2_q <= te1_q; tep_q <= te2_q;
    end
  end

  logic ce_fall, te_fall, tte_on;
  assign ce_fall = cep_q && !ce2_q;
  assign te_fall = tep_q && !te2_q;
  assign tte_on  = !te2_q;

  // ---------------- tick prescaler ----------------
  logic [PSW-1:0] ps_q;
  logic           tick;
  assign tick = (ps_q == PSW'(PRESCALE - 1));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ps_q <= '0;
    else if (tick) ps_q <= '0;
    else           ps_q <= ps_q + 1'b1;
  end

  // ---------------- state and timers ----------------
  chg_state_t st_q, st_nxt;
  logic       susp, clr_fsm, clr_all, seen_q;
  logic       pre_exp, tap_exp, fast_exp;
  logic [PW-1:0] pre_cnt;
  logic [TW-1:0] tap_cnt;
  logic [FW-1:0] fast_cnt;
  logic       in_fast_run;

  assign susp        = f_suspend(flt[F_TEMP], flt[F_HOT]);
  assign in_fast_run = (st_q == ST_FAST) && !susp;
  assign clr_all     = clr_fsm || te_fall;

  chg_timer #(.LIMIT(PRE_TICKS)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_all), .zero_i(1'b0),
    .step_i((st_q == ST_PRE) && !susp && tick), .cnt_o(pre_cnt), .exp_o(pre_exp));

  chg_timer #(.LIMIT(FAST_TICKS)) u_fast (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_all), .zero_i(1'b0),
    .step_i(in_fast_run && tte_on && tick), .cnt_o(fast_cnt), .exp_o(fast_exp));

  chg_timer #(.LIMIT(TAPER_TICKS)) u_tap (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_all), .zero_i(in_fast_run && !flt[F_TAPER]),
    .step_i(in_fast_run && flt[F_TAPER] && tick), .cnt_o(tap_cnt), .exp_o(tap_exp));

  chg_state_t restart_st;
  assign restart_st = flt[F_LOW] ? ST_PRE : ST_FAST;

  always_comb begin
    st_nxt  = st_q;
    clr_fsm = 1'b0;
    if (!flt[F_SUPPLY]) begin
      st_nxt = ST_SLEEP;
    end else if (ce2_q) begin
      st_nxt = ST_DIS;
    end else if (ce_fall || st_q == ST_SLEEP || st_q == ST_DIS) begin
      st_nxt  = restart_st;
      clr_fsm = 1'b1;
    end else begin
      unique case (st_q)
        ST_PRE: begin
          if (!flt[F_LOW]) begin
            st_nxt  = ST_FAST;
            clr_fsm = 1'b1;
          end else if (pre_exp) begin
            st_nxt = ST_FAULT;
          end
        end
        ST_FAST: begin
          if (!susp && tte_on) begin
            if (flt[F_TERM] || tap_exp) st_nxt = ST_DONE;
            else if (fast_exp)          st_nxt = ST_FAULT;
          end
        end
        ST_DONE:  if (!flt[F_FULL]) st_nxt = ST_ABS;
        ST_ABS: begin
          if (chk_done_i) begin
            if (chk_present_i) begin
              st_nxt  = restart_st;
              clr_fsm = 1'b1;
            end else begin
              st_nxt = ST_NOBAT;
            end
          end
        end
        ST_FAULT: if (seen_q && !flt[F_FULL]) st_nxt = ST_ABS;
        default: st_nxt = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SLEEP;
      seen_q <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      seen_q <= (st_q == ST_FAULT) && (seen_q || flt[F_FULL]);
    end
  end

  // ---------------- outputs ----------------
  assign mode_o     = f_mode(st_q, susp, flt[F_SHORT]);
  assign stat1_on_o = (st_q == ST_PRE || st_q == ST_FAST) && !susp;
  assign stat2_on_o = (st_q == ST_DONE);
  assign pgood_o    = flt[F_SUPPLY];
  assign chk_req_o  = (st_q == ST_ABS);

  // ---------------- assertions ----------------
  // R1 / R2: a fault is only ever entered from an expired safety timer
  p_fault_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_FAULT) |-> $past(pre_exp || fast_exp));

  // R2: fast charge always starts with cleared timers
  p_fast_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_FAST) |-> (pre_cnt == '0 && fast_cnt == '0 && tap_cnt == '0));

  // R4 / R3: done is only entered on termination or taper expiry
  p_done_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_DONE) |-> $past(flt[F_TERM] || tap_exp));

  // R5: timers freeze during a suspend
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (susp && !clr_all) |=> ($stable(pre_cnt) && $stable(fast_cnt) && $stable(tap_cnt)));

  // R5: no current while suspended
  p_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    susp |-> (mode_o == 2'b00));

  // R8: the two status indications are never both on
  p_stat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stat1_on_o, stat2_on_o}));

  // R10: a lost supply always leads to sleep, with outputs quiet there
  p_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !flt[F_SUPPLY] |=> (st_q == ST_SLEEP));
  p_sleep_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLEEP) |-> (!stat1_on_o && !stat2_on_o && mode_o == 2'b00));
endmodule

// File: tb/sim_li_charge_seq.sv
`timescale 1ns/1ps
module sim_li_charge_seq;
  localparam int DEB = 3, PS = 2, PRE_T = 20, TAP_T = 10, FAST_T = 60;
  localparam int S_SLEEP = 0, S_DIS = 1, S_PRE = 2, S_FAST = 3,
                 S_DONE = 4, S_ABS = 5, S_FAULT = 6, S_NOBAT = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bat_low = 0, bat_short = 0, bat_full = 0, taper = 0, term = 0;
  logic temp_ok = 1, die_hot = 0, supply = 0, ce_n = 1, te_n = 0;
  logic chk_done = 0, chk_present = 0;
  logic [1:0] mode;
  logic stat1, stat2, pgood, chk_req;

  always #2 clk = ~clk;

  li_charge_seq #(.DEB_CYC(DEB), .PRESCALE(PS), .PRE_TICKS(PRE_T),
                  .TAPER_TICKS(TAP_T), .FAST_TICKS(FAST_T)) u0 (
    .clk(clk), .rst_n(rst_n), .bat_low_i(bat_low), .bat_short_i(bat_short),
    .bat_full_i(bat_full), .taper_i(taper), .term_i(term), .temp_ok_i(temp_ok),
    .die_hot_i(die_hot), .supply_ok_i(supply), .chg_en_n_i(ce_n),
    .tmr_en_n_i(te_n), .chk_done_i(chk_done), .chk_present_i(chk_present),
    .mode_o(mode), .stat1_on_o(stat1), .stat2_on_o(stat2), .pgood_o(pgood),
    .chk_req_o(chk_req));

  int n_vec = 0, n_bad = 0;
  string phase = "R10";
  bit running = 0;

  // ---------------- reference model ----------------
  bit [7:0] m_raw, m_y1, m_y2, m_deb;
  int m_dc[8];
  bit m_c1, m_c2, m_cp, m_t1, m_t2, m_tp, m_seen;
  int m_pc, m_pre, m_fast, m_tap, m_st;

  function automatic bit m_susp();
    return !m_deb[5] || m_deb[6];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_y1 = 0; m_y2 = 0; m_deb = 0;
      foreach (m_dc[i]) m_dc[i] = 0;
      {m_c1, m_c2, m_cp, m_t1, m_t2, m_tp} = 6'h3f;
      m_pc = 0; m_pre = 0; m_fast = 0; m_tap = 0; m_st = S_SLEEP; m_seen = 0;
    end else begin
      bit susp, tick, cef, tef, tton, clr;
      int nst, rs;
      m_raw = {supply, die_hot, temp_ok, term, taper, bat_full, bat_short, bat_low};
      susp = m_susp();
      tick = (m_pc == PS - 1);
      cef  = m_cp && !m_c2;
      tef  = m_tp && !m_t2;
      tton = !m_t2;
      rs   = m_deb[0] ? S_PRE : S_FAST;
      nst  = m_st; clr = 0;
      if (!m_deb[7]) nst = S_SLEEP;
      else if (m_c2) nst = S_DIS;
      else if (cef || m_st == S_SLEEP || m_st == S_DIS) begin nst = rs; clr = 1; end
      else begin
        case (m_st)
          S_PRE: if (!m_deb[0]) begin nst = S_FAST; clr = 1; end
                 else if (m_pre >= PRE_T) nst = S_FAULT;
          S_FAST: if (!susp && tton) begin
                    if (m_deb[4] || m_tap >= TAP_T) nst = S_DONE;
                    else if (m_fast >= FAST_T) nst = S_FAULT;
                  end
          S_DONE: if (!m_deb[2]) nst = S_ABS;
          S_ABS: if (chk_done) begin
                   if (chk_present) begin nst = rs; clr = 1; end
                   else nst = S_NOBAT;
                 end
          S_FAULT: if (m_seen && !m_deb[2]) nst = S_ABS;
          default: ;
        endcase
      end
      if (clr || tef) begin m_pre = 0; m_fast = 0; m_tap = 0; end
      else begin
        if (m_st == S_PRE && !susp && tick && m_pre < PRE_T) m_pre++;
        if (m_st == S_FAST && !susp) begin
          if (tton && tick && m_fast < FAST_T) m_fast++;
          if (!m_deb[3]) m_tap = 0;
          else if (tick && m_tap < TAP_T) m_tap++;
        end
      end
      m_seen = (m_st == S_FAULT) && (m_seen || m_deb[2]);
      m_st = nst;
      for (int i = 0; i < 8; i++) begin
        if (m_y2[i] == m_deb[i]) m_dc[i] = 0;
        else if (m_dc[i] == DEB - 1) begin m_deb[i] = m_y2[i]; m_dc[i] = 0; end
        else m_dc[i]++;
      end
      m_y2 = m_y1; m_y1 = m_raw;
      m_cp = m_c2; m_c2 = m_c1; m_c1 = ce_n;
      m_tp = m_t2; m_t2 = m_t1; m_t1 = te_n;
      m_pc = tick ? 0 : m_pc + 1;
    end
  end

  task automatic check_all();
    bit susp;
    logic [1:0] em;
    bit e1, e2, eg, er;
    susp = m_susp();
    em = 2'b00;
    if (!susp && m_st == S_PRE)  em = m_deb[1] ? 2'b01 : 2'b10;
    if (!susp && m_st == S_FAST) em = 2'b11;
    e1 = (m_st == S_PRE || m_st == S_FAST) && !susp;
    e2 = (m_st == S_DONE);
    eg = m_deb[7];
    er = (m_st == S_ABS);
    n_vec++;
    if ({mode, stat1, stat2, pgood, chk_req} !== {em, e1, e2, eg, er}) begin
      n_bad++;
      $display("FAIL %s t=%0t mode/s1/s2/pg/req got %b %b %b %b %b exp %b %b %b %b %b",
               phase, $time, mode, stat1, stat2, pgood, chk_req, em, e1, e2, eg, er);
    end
  endtask

  always @(negedge clk) if (running) check_all();

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic serve_absent(bit present);
    for (int i = 0; i < 200 && !chk_req; i++) @(negedge clk);
    chk_present = present; chk_done = 1'b1;
    @(negedge clk);
    chk_done = 1'b0;
    cyc(10);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired in phase %s", phase);
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    running = 1;
    // reset state: sleep with everything off (R10)
    phase = "R10"; cyc(8);
    supply = 1; bat_low = 1; ce_n = 0; bat_full = 0;
    cyc(15);
    phase = "R12"; bat_short = 1; cyc(15); bat_short = 0; cyc(10);
    phase = "R1"; cyc(40);                       // precharge timer runs out
    phase = "R13"; bat_full = 1; cyc(15); bat_full = 0; cyc(15);
    phase = "R9"; serve_absent(1);               // restart into precharge
    phase = "R6"; ce_n = 1; cyc(15); ce_n = 0; cyc(15);
    phase = "R1"; bat_low = 0; cyc(15);          // precharge -> fast
    phase = "R5"; temp_ok = 0; cyc(30); temp_ok = 1; cyc(12);
    die_hot = 1; cyc(20); die_hot = 0; cyc(12);
    phase = "R3"; bat_full = 1; taper = 1; cyc(12); taper = 0; cyc(10);
    taper = 1; cyc(40);                          // taper timer expires -> done
    phase = "R9"; bat_full = 0; cyc(12); serve_absent(0);
    phase = "R6"; taper = 0; ce_n = 1; cyc(10); ce_n = 0; cyc(15);
    phase = "R7"; te_n = 1; cyc(6); term = 1; cyc(160);
    phase = "R4"; te_n = 0; cyc(15);             // pin falls: termination acts
    phase = "R2"; term = 0; ce_n = 1; cyc(10); ce_n = 0; cyc(140);
    phase = "R11"; ce_n = 1; cyc(10); ce_n = 0; cyc(10);
    supply = 0; cyc(2); supply = 1; cyc(12);     // short drop ignored
    supply = 0; cyc(12); supply = 1; cyc(15);    // long drop sleeps
    phase = "R8"; cyc(10);
    finish_run();
  end
endmodule